// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits in a host bridge and steers every access that lands in the legacy hole below one megabyte. For each access address it picks one of three outcomes: the access goes to system DRAM, it is passed on to the expansion bus, or it is a write that is refused because its segment is read-only. Addresses outside the legacy hole always go to DRAM.

The region from 0xC0000 to 0xFFFFF is split into twelve 16 KB segments (0xC0000 to 0xEFFFF) and one 64 KB top segment (0xF0000 to 0xFFFFF). Each segment has its own 2-bit attribute code, held in seven byte-wide attribute registers. The 0xA0000 to 0xBFFFF window is controlled by a separate window control register. The window opens to DRAM through an open bit, or through an enable bit while the processor reports that system-management mode is active. A byte-wide write port loads these registers. Address decode is combinational, so the outputs follow the access address, the access direction and the mode input in the same cycle.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset every attribute byte is 0x00 and the window control byte is 0x02. All of 0xA0000 to 0xFFFFF therefore goes to the expansion bus while `smm_active` is low.
- R2: An access whose address bits above bit 19 are not all zero, or whose low 20 bits are below 0xA0000, asserts `sel_dram` only. This holds for any direction and any register contents.
- R3: In every cycle, exactly one of `sel_dram`, `sel_bus` and `wr_blocked` is high.
- R4: The top segment 0xF0000 to 0xFFFFF takes its code from bits 5:4 of the attribute byte at offset 0x59.
- R5: Segment i (0 to 11) covers 0xC0000 + i*0x4000 up to the next 16 KB boundary. It takes its code from the attribute byte at offset 0x5A + i/2: bits 1:0 when i is even, bits 5:4 when i is odd. Bits 7:6 and 3:2 of every attribute byte have no effect.
- R6: Code 3 sends both reads and writes to DRAM.
- R7: Code 1 sends reads to DRAM. A write under code 1 raises `wr_blocked` and asserts neither select. A read never raises `wr_blocked`.
- R8: Codes 0 and 2 send both reads and writes to the expansion bus.
- R9: When bit 6 of the window control byte (offset 0x72) is set, the 0xA0000 to 0xBFFFF window goes to DRAM whatever the value of `smm_active`.
- R10: When bit 6 of the window control byte is clear, the window goes to DRAM exactly when bit 3 is set and `smm_active` is high, and otherwise goes to the bus. A change of `smm_active` acts on the decode in the same cycle, with no register write.
- R11: A register write takes effect in the cycle after the clock edge that samples it. Writes to offsets other than 0x59 to 0x5F and 0x72 change no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Byte register write strobe |
| reg_addr | input | 8 | Register offset of the write |
| reg_wdata | input | 8 | Byte to write |
| smm_active | input | 1 | High while the processor runs in system-management mode |
| acc_addr | input | ADDR_W | Physical address of the current access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| sel_dram | output | 1 | Access goes to system DRAM |
| sel_bus | output | 1 | Access is forwarded to the expansion bus |
| wr_blocked | output | 1 | Write refused because its segment is read-only |

## Verification
The bench builds the block with its default 24-bit address, so addresses above one megabyte are available to test the outside-region rule next to the low-memory case. Five register patterns rotate the 2-bit codes so that each of the thirteen segments sees all four codes, and they fill the unused attribute bits with ones. Each pattern is swept at the start, middle and last byte of every 16 KB block from 0x80000 to 0x10FFFF, in both directions and with the mode input high and low. Every segment edge and every window control combination is therefore reached against an arithmetic model. Writes to the neighbouring unmapped offsets are mixed into every pattern.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

  typedef enum logic [1:0] {
    ATTR_BUS     = 2'd0,
    ATTR_RO      = 2'd1,
    ATTR_BUS_ALT = 2'd2,
    ATTR_RW      = 2'd3
  } attr_code_e;

  typedef enum logic [1:0] {
    REG_OUTSIDE = 2'd0,
    REG_WINDOW  = 2'd1,
    REG_SEG     = 2'd2,
    REG_TOP     = 2'd3
  } region_e;

  localparam logic [19:0] WIN_LO = 20'hA0000;
  localparam logic [19:0] SEG_LO = 20'hC0000;
  localparam logic [19:0] TOP_LO = 20'hF0000;

  // Region of an access from its low 20 bits and an above-1MB flag.
  function automatic region_e classify(input logic above, input logic [19:0] a);
    if (above || a < WIN_LO) return REG_OUTSIDE;
    if (a < SEG_LO)          return REG_WINDOW;
    if (a < TOP_LO)          return REG_SEG;
    return REG_TOP;
  endfunction

  // 2-bit code held in one nibble of an attribute byte.
  function automatic logic [1:0] seg_field(input logic [7:0] b, input logic hi);
    return hi ? b[5:4] : b[1:0];
  endfunction

  // Window open: bit 6 alone, or bit 3 with the mode input high.
  function automatic logic window_open(input logic [7:0] ctl, input logic smm);
    return ctl[6] | (ctl[3] & smm);
  endfunction

endpackage

// File: rtl/ldec_cfg_regs.sv
module ldec_cfg_regs #(
  parameter int          NUM_ATTR  = 7,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  CTL_OFS   = 8'h72,
  parameter logic [7:0]  CTL_RST   = 8'h02
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [7:0]                addr,
  input  logic [7:0]                wdata,
  output logic [NUM_ATTR-1:0][7:0]  attr_q,
  output logic [7:0]                ctl_q
);

  for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
    localparam logic [7:0] OFS = ATTR_BASE + 8'(g);
    logic hit;
    assign hit = wr_en && (addr == OFS);
    always_ff @(posedge clk) begin
      if (!rst_n)   attr_q[g] <= 8'h00;
      else if (hit) attr_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctl_q <= CTL_RST;
    else if (wr_en && addr == CTL_OFS)   ctl_q <= wdata;
  end

endmodule

// File: rtl/ldec_region_decode.sv
module ldec_region_decode
  import ldec_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_SEG  = 12,
  parameter int NUM_ATTR = 1 + NUM_SEG / 2
) (
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [NUM_ATTR-1:0][7:0]  attr_q,
  output region_e                   region,
  output attr_code_e                code
);

  localparam logic [3:0] SEG_LIMIT = 4'(NUM_SEG);

  logic        above;
  logic [19:0] low;
  logic [3:0]  seg_idx;
  logic [NUM_SEG-1:0][1:0] seg_codes;

  if (ADDR_W > 20) begin : g_wide
    assign above = |acc_addr[ADDR_W-1:20];
  end else begin : g_narrow
    assign above = 1'b0;
  end

  assign low     = acc_addr[19:0];
  assign seg_idx = low[17:14];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    assign seg_codes[g] = seg_field(attr_q[1 + g / 2], (g % 2) == 1);
  end

  always_comb begin
    region = classify(above, low);
    code   = ATTR_BUS;
    case (region)
      REG_TOP: code = attr_code_e'(seg_field(attr_q[0], 1'b1));
      REG_SEG: code = (seg_idx < SEG_LIMIT) ? attr_code_e'(seg_codes[seg_idx]) : ATTR_BUS;
      default: code = ATTR_BUS;
    endcase
  end

endmodule

// File: rtl/ldec_route.sv
module ldec_route
  import ldec_pkg::*;
(
  input  region_e     region,
  input  attr_code_e  code,
  input  logic        acc_write,
  input  logic        win_open,
  output logic        sel_dram,
  output logic        sel_bus,
  output logic        wr_blocked
);

  always_comb begin
    sel_dram   = 1'b0;
    sel_bus    = 1'b0;
    wr_blocked = 1'b0;
    case (region)
      REG_OUTSIDE: sel_dram = 1'b1;
      REG_WINDOW: begin
        if (win_open) sel_dram = 1'b1;
        else          sel_bus  = 1'b1;
      end
      default: begin
        case (code)
          ATTR_RW: sel_dram = 1'b1;
          ATTR_RO: begin
            if (acc_write) wr_blocked = 1'b1;
            else           sel_dram   = 1'b1;
          end
          default: sel_bus = 1'b1;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import ldec_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          NUM_SEG   = 12,
  parameter logic [7:0]  ATTR_BASE = 8'h59,
  parameter logic [7:0]  CTL_OFS   = 8'h72,
  parameter logic [7:0]  CTL_RST   = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              sel_dram,
  output logic              sel_bus,
  output logic              wr_blocked
);

  localparam int NUM_ATTR = 1 + NUM_SEG / 2;

  logic [NUM_ATTR-1:0][7:0] attr_q;
  logic [7:0]               ctl_q;
  logic                     win_open;
  region_e                  region;
  attr_code_e               code;

  ldec_cfg_regs #(
    .NUM_ATTR (NUM_ATTR),
    .ATTR_BASE(ATTR_BASE),
    .CTL_OFS  (CTL_OFS),
    .CTL_RST  (CTL_RST)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .attr_q(attr_q),
    .ctl_q (ctl_q)
  );

  assign win_open = window_open(ctl_q, smm_active);

  ldec_region_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_SEG (NUM_SEG),
    .NUM_ATTR(NUM_ATTR)
  ) u_dec (
    .acc_addr(acc_addr),
    .attr_q  (attr_q),
    .region  (region),
    .code    (code)
  );

  ldec_route u_route (
    .region    (region),
    .code      (code),
    .acc_write (acc_write),
    .win_open  (win_open),
    .sel_dram  (sel_dram),
    .sel_bus   (sel_bus),
    .wr_blocked(wr_blocked)
  );

endmodule

// File: rtl/ldec_checker.sv
module ldec_checker #(
  parameter int         ADDR_W  = 24,
  parameter logic [7:0] CTL_OFS = 8'h72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [7:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              smm_active,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              sel_dram,
  input logic              sel_bus,
  input logic              wr_blocked,
  input logic [7:0]        ctl_q
);

  logic above, outside, in_win, ctl_hit;

  if (ADDR_W > 20) begin : g_wide
    assign above = |acc_addr[ADDR_W-1:20];
  end else begin : g_narrow
    assign above = 1'b0;
  end

  assign outside = above || (acc_addr[19:0] < 20'hA0000);
  assign in_win  = !above && (acc_addr[19:17] == 3'b101);
  assign ctl_hit = reg_wr_en && (reg_addr == CTL_OFS);

  p_one_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_dram, sel_bus, wr_blocked}) == 1);

  p_outside_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> sel_dram);

  p_read_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !wr_blocked);

  p_open_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && ctl_q[6]) |-> sel_dram);

  p_smm_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && ctl_q[3] && smm_active) |-> sel_dram);

  p_closed_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !ctl_q[6] && !(ctl_q[3] && smm_active)) |-> sel_bus);

  p_ctl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> (ctl_q == $past(reg_wdata)));

  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_hit |=> $stable(ctl_q));

endmodule

bind legacy_mem_decoder ldec_checker #(
  .ADDR_W (ADDR_W),
  .CTL_OFS(CTL_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .smm_active(smm_active),
  .acc_addr  (acc_addr),
  .acc_write (acc_write),
  .sel_dram  (sel_dram),
  .sel_bus   (sel_bus),
  .wr_blocked(wr_blocked),
  .ctl_q     (ctl_q)
);

// File: tb/sim_legacy_mem_decoder.sv
module sim_legacy_mem_decoder;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [7:0]    reg_addr = 8'h00;
  logic [7:0]    reg_wdata = 8'h00;
  logic          smm_active = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          sel_dram, sel_bus, wr_blocked;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_ctl;

  always #10 clk = ~clk;

  legacy_mem_decoder #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .smm_active(smm_active), .acc_addr(acc_addr),
    .acc_write(acc_write), .sel_dram(sel_dram), .sel_bus(sel_bus),
    .wr_blocked(wr_blocked)
  );

  // Expected {dram, bus, blocked} from the requirement text.
  function automatic logic [2:0] model(input int unsigned a, input logic wr, input logic smm);
    int unsigned i;
    logic [7:0]  b;
    logic [1:0]  c;
    if (a < 32'hA0000 || a >= 32'h100000) return 3'b100;
    if (a < 32'hC0000) return (m_ctl[6] || (m_ctl[3] && smm)) ? 3'b100 : 3'b010;
    if (a >= 32'hF0000) c = 2'((m_attr[0] >> 4) & 8'h3);
    else begin
      i = (a - 32'hC0000) / 32'h4000;
      b = m_attr[1 + i / 2];
      c = (i % 2 == 1) ? 2'((b >> 4) & 8'h3) : 2'(b & 8'h3);
    end
    if (c == 2'd3) return 3'b100;
    if (c == 2'd1) return wr ? 3'b001 : 3'b100;
    return 3'b010;
  endfunction

  function automatic string tag_of(input int unsigned a);
    logic [1:0] c;
    if (a < 32'hA0000 || a >= 32'h100000) return "R2";
    if (a < 32'hC0000) return m_ctl[6] ? "R9" : "R10";
    c = 2'(model(a, 1'b0, 1'b0) == 3'b010 ? 0 : (model(a, 1'b1, 1'b0) == 3'b001 ? 1 : 3));
    if (c == 2'd3) return (a >= 32'hF0000) ? "R4/R6" : "R5/R6";
    if (c == 2'd1) return (a >= 32'hF0000) ? "R4/R7" : "R5/R7";
    return (a >= 32'hF0000) ? "R4/R8" : "R5/R8";
  endfunction

  task automatic wr_reg(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic probe(input int unsigned a, input logic wr, input logic smm, input string tag);
    logic [2:0] exp, got;
    @(negedge clk);
    acc_addr = AW'(a); acc_write = wr; smm_active = smm;
    #2;
    got = {sel_dram, sel_bus, wr_blocked};
    exp = model(a, wr, smm);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b smm=%0b got=%b exp=%b", tag, a, wr, smm, got, exp);
    end
    checks++;
    if ($countones(got) != 1) begin
      fails++;
      $display("FAIL R3 addr=%h got=%b exp=one-hot", a, got);
    end
  endtask

  task automatic sweep(input logic rst_phase);
    int unsigned offs [3] = '{32'h0, 32'h2000, 32'h3FFF};
    for (int unsigned blk = 32'h80000; blk < 32'h110000; blk += 32'h4000) begin
      for (int k = 0; k < 3; k++) begin
        for (int w = 0; w < 2; w++) begin
          for (int s = 0; s < 2; s++) begin
            probe(blk + offs[k], w[0], s[0], rst_phase ? "R1" : tag_of(blk + offs[k]));
          end
        end
      end
    end
    probe(32'hFFFFFF, 1'b1, 1'b0, "R2");
    probe(32'h000000, 1'b0, 1'b1, "R2");
  endtask

  initial begin
    logic [7:0] ctl_pat [5] = '{8'h02, 8'h08, 8'h40, 8'h48, 8'hB7};
    for (int j = 0; j < 7; j++) m_attr[j] = 8'h00;
    m_ctl = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    sweep(1'b1);
    for (int p = 0; p < 5; p++) begin
      logic [7:0] b;
      // F segment: bits 5:4, junk elsewhere (R4, R5 unused bits)
      b = 8'hCF | (8'((12 + p) % 4) << 4);
      m_attr[0] = b; wr_reg(8'h59, b);
      for (int j = 1; j < 7; j++) begin
        b = 8'hCC | 8'(((2 * (j - 1)) + p) % 4) | (8'(((2 * (j - 1) + 1) + p) % 4) << 4);
        m_attr[j] = b; wr_reg(8'h59 + 8'(j), b);
      end
      m_ctl = ctl_pat[p]; wr_reg(8'h72, ctl_pat[p]);
      // R11: unmapped offsets ignored
      wr_reg(8'h58, 8'hFF); wr_reg(8'h60, 8'hFF);
      wr_reg(8'h71, 8'hFF); wr_reg(8'h73, 8'hFF);
      sweep(1'b0);
    end
    // R11: new window control value visible on the cycle after the write edge
    m_ctl = 8'h40;
    @(negedge clk);
    acc_addr = AW'(32'hA8000); acc_write = 1'b0; smm_active = 1'b0;
    reg_wr_en = 1'b1; reg_addr = 8'h72; reg_wdata = 8'h40;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #2;
    checks++;
    if ({sel_dram, sel_bus, wr_blocked} !== 3'b100) begin
      fails++;
      $display("FAIL R11 got=%b exp=100", {sel_dram, sel_bus, wr_blocked});
    end
    // R10: mode input alone reopens the window, no write
    m_ctl = 8'h08; wr_reg(8'h72, 8'h08);
    probe(32'hB0000, 1'b0, 1'b0, "R10");
    probe(32'hB0000, 1'b0, 1'b1, "R10");
    probe(32'hB0000, 1'b1, 1'b0, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule